// File: doc/BRIEF.md
# Serial Register Bus Command Front-End

This block sits between a host with a 32-bit register window and a byte-wide serial register bus controller. The host starts one single-byte read or write at a time by writing a command word. The block then holds a request on an abstract target port until the target acknowledges. The target address is 15 bits wide. Its low byte comes from the command word. Its upper seven bits come from a mode register that the host loads beforehand.

Reads and writes finish on different status conditions. A write is done when the busy flag drops. A read is done when the read-available flag rises, and the byte is then in the read-data register. Before each new command the host must see the ready flag set. It also enforces its own timeout: a transaction normally takes a few microseconds and is abandoned after about a hundred.

The engine has three states: `ST_IDLE`, `ST_WR_WAIT` and `ST_RD_WAIT`. It has four transitions:
- `ST_IDLE` to `ST_WR_WAIT` on an accepted command with the read bit clear.
- `ST_IDLE` to `ST_RD_WAIT` on an accepted command with the read bit set.
- `ST_WR_WAIT` to `ST_IDLE` on target acknowledge.
- `ST_RD_WAIT` to `ST_IDLE` on target acknowledge, which also captures the read byte.

Top module: `sbus_cmd_frontend`

## Requirements
- R1: After reset, the status register (offset 0x14) reads 0x2, which is ready=1, busy=0 and read-available=0. The command (0x08), read-data (0x10) and mode (0x1C) registers read 0.
- R2: Command word fields: bit 24 = 1 means read and 0 means write; bits 23:16 are the low address byte; bits 7:0 are the write data. A command written while ready is set is accepted. On the next cycle status reads busy (bit 0) set and ready (bit 1) clear. On that cycle the target port also shows `tgt_req`=1, `tgt_we` equal to the inverse of bit 24, and the write data.
- R3: The target address is {mode bits 10:4, command bits 23:16}, captured when the command is accepted. A mode write made while a transaction is pending does not change the address of that transaction.
- R4: A write ends on the edge where `tgt_ack` is sampled high. From the next cycle status reads ready=1, busy=0, and `tgt_req` is low.
- R5: A read ends on the same acknowledge. From the next cycle status reads 0x6, and bits 7:0 of the read-data register hold the byte the target returned.
- R6: A command-register write while ready is clear is ignored. The command readback is unchanged and no further target transaction is started.
- R7: The read-available flag (status bit 2) clears on the cycle after the host reads the read-data register. It also clears on the cycle after a new command is accepted.
- R8: The mode register keeps bits 10:0 and reads them back. Bits 3:0 form an independent mode field. All other mode bits, and command bits 31:25 and 15:8, read as 0.
- R9: While `tgt_req` is high and not yet acknowledged, `tgt_req`, `tgt_we`, `tgt_addr` and `tgt_wdata` hold steady.
- R10: The read-data register keeps its byte after read-available clears, until the next read completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr_en | input | 1 | Host register write strobe |
| host_rd_en | input | 1 | Host register read strobe (side effect on read-data offset) |
| host_addr | input | 8 | Host byte offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Register readback for `host_addr` (combinational) |
| tgt_req | output | 1 | Request to the target, held until acknowledge |
| tgt_we | output | 1 | 1 for write, 0 for read |
| tgt_addr | output | 15 | Target register address |
| tgt_wdata | output | 8 | Write byte |
| tgt_rdata | input | 8 | Read byte, valid with acknowledge |
| tgt_ack | input | 1 | Target acknowledge, one cycle |

## Verification
A wrong engine state shows up at the ports one cycle after the edge that caused it. It appears either as status that says ready while `tgt_req` is still high, or as a request that never drops after acknowledge. A wrong captured address or data byte appears on the target port during the request itself. A stale read-available flag can be seen in status on the first poll after the read-data register is read. A stale flag can also remain after a new command is accepted. An ignored command that leaks through changes the command readback at once, and the target sees an extra write.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
    // Host register offsets
    localparam logic [7:0] OFS_CMD  = 8'h08;
    localparam logic [7:0] OFS_RDAT = 8'h10;
    localparam logic [7:0] OFS_STAT = 8'h14;
    localparam logic [7:0] OFS_MODE = 8'h1C;

    // Command word layout
    localparam int CMD_RW_BIT  = 24;
    localparam int CMD_LO_LSB  = 16;
    localparam int CMD_DAT_LSB = 0;

    // Mode word layout
    localparam int MODE_HI_LSB = 4;
    localparam int MODE_FLD_W  = 4;

    // Status bits
    localparam int STAT_BUSY  = 0;
    localparam int STAT_READY = 1;
    localparam int STAT_AVAIL = 2;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_WR_WAIT = 2'd1,
        ST_RD_WAIT = 2'd2
    } eng_state_t;
endpackage

// File: rtl/sbus_engine.sv
module sbus_engine
    import sbus_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic          acc_read,
    input  logic [AW-1:0] acc_addr,
    input  logic [DW-1:0] acc_data,
    input  logic          rdat_pop,
    input  logic          tgt_ack,
    input  logic [DW-1:0] tgt_rdata,
    output logic          tgt_req,
    output logic          tgt_we,
    output logic [AW-1:0] tgt_addr,
    output logic [DW-1:0] tgt_wdata,
    output logic          ready,
    output logic          busy,
    output logic          avail,
    output logic [DW-1:0] rd_byte
);
    eng_state_t state_q, state_d;

    logic take_cmd;
    logic rd_done;

    assign take_cmd = accept && (state_q == ST_IDLE);
    assign rd_done  = (state_q == ST_RD_WAIT) && tgt_ack;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (take_cmd) state_d = acc_read ? ST_RD_WAIT : ST_WR_WAIT;
            ST_WR_WAIT: if (tgt_ack)  state_d = ST_IDLE;
            ST_RD_WAIT: if (tgt_ack)  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State-decoded outputs
    always_comb begin
        ready   = 1'b0;
        busy    = 1'b0;
        tgt_req = 1'b0;
        tgt_we  = 1'b0;
        unique case (state_q)
            ST_IDLE:    ready = 1'b1;
            ST_WR_WAIT: begin busy = 1'b1; tgt_req = 1'b1; tgt_we = 1'b1; end
            ST_RD_WAIT: begin busy = 1'b1; tgt_req = 1'b1; end
            default:    ready = 1'b0;
        endcase
    end

    // Request fields, captured at acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_addr  <= '0;
            tgt_wdata <= '0;
        end else if (take_cmd) begin
            tgt_addr  <= acc_addr;
            tgt_wdata <= acc_data;
        end
    end

    // Read byte and read-available flag; completion outranks a pop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_byte <= '0;
            avail   <= 1'b0;
        end else begin
            if (rd_done) rd_byte <= tgt_rdata;
            if (rd_done)                    avail <= 1'b1;
            else if (take_cmd || rdat_pop)  avail <= 1'b0;
        end
    end

    a_r2_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && ready) |=> (busy && tgt_req && !ready && !avail));

    a_r4_ack_completes: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_req && tgt_ack) |=> (ready && !busy && !tgt_req));

    a_r5_read_sets_avail: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_req && !tgt_we && tgt_ack) |=> (avail && rd_byte == $past(tgt_rdata)));

    a_r7_pop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rdat_pop && !(tgt_req && !tgt_we && tgt_ack)) |=> !avail);

    a_r9_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_req && !tgt_ack) |=> (tgt_req && $stable(tgt_addr) && $stable(tgt_wdata) && $stable(tgt_we)));
endmodule

// File: rtl/sbus_regwin.sv
module sbus_regwin
    import sbus_pkg::*;
#(
    parameter int HAW = 8,
    parameter int HDW = 32,
    parameter int DW  = 8,
    parameter int LAW = 8,
    parameter int UAW = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_wr_en,
    input  logic               host_rd_en,
    input  logic [HAW-1:0]     host_addr,
    input  logic [HDW-1:0]     host_wdata,
    output logic [HDW-1:0]     host_rdata,
    input  logic               ready,
    input  logic               busy,
    input  logic               avail,
    input  logic [DW-1:0]      rd_byte,
    output logic               accept,
    output logic               acc_read,
    output logic [UAW+LAW-1:0] acc_addr,
    output logic [DW-1:0]      acc_data,
    output logic               rdat_pop
);
    localparam int MODE_W = MODE_HI_LSB + UAW;

    logic              cmd_rd_q;
    logic [LAW-1:0]    cmd_lo_q;
    logic [DW-1:0]     cmd_dat_q;
    logic [MODE_W-1:0] mode_q;
    logic              wr_cmd, wr_mode;
    logic              unused_wbits;

    assign wr_cmd   = host_wr_en && (host_addr == HAW'(OFS_CMD));
    assign wr_mode  = host_wr_en && (host_addr == HAW'(OFS_MODE));
    assign accept   = wr_cmd && ready;
    assign rdat_pop = host_rd_en && (host_addr == HAW'(OFS_RDAT));

    assign acc_read = host_wdata[CMD_RW_BIT];
    assign acc_addr = {mode_q[MODE_W-1:MODE_HI_LSB], host_wdata[CMD_LO_LSB +: LAW]};
    assign acc_data = host_wdata[CMD_DAT_LSB +: DW];

    assign unused_wbits = ^{host_wdata[HDW-1:CMD_RW_BIT+1], host_wdata[CMD_LO_LSB-1:DW]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_rd_q  <= 1'b0;
            cmd_lo_q  <= '0;
            cmd_dat_q <= '0;
        end else if (accept) begin
            cmd_rd_q  <= acc_read;
            cmd_lo_q  <= host_wdata[CMD_LO_LSB +: LAW];
            cmd_dat_q <= acc_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= '0;
        else if (wr_mode) mode_q <= host_wdata[MODE_W-1:0];
    end

    always_comb begin
        host_rdata = '0;
        unique case (host_addr)
            HAW'(OFS_CMD): begin
                host_rdata[CMD_RW_BIT]          = cmd_rd_q;
                host_rdata[CMD_LO_LSB +: LAW]   = cmd_lo_q;
                host_rdata[CMD_DAT_LSB +: DW]   = cmd_dat_q;
            end
            HAW'(OFS_RDAT): host_rdata[DW-1:0] = rd_byte;
            HAW'(OFS_STAT): begin
                host_rdata[STAT_BUSY]  = busy;
                host_rdata[STAT_READY] = ready;
                host_rdata[STAT_AVAIL] = avail;
            end
            HAW'(OFS_MODE): host_rdata[MODE_W-1:0] = mode_q;
            default:        host_rdata = '0;
        endcase
    end

    a_r6_ignored_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && busy) |=> ($stable(cmd_lo_q) && $stable(cmd_dat_q) && $stable(cmd_rd_q)));

    a_r8_mode_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_mode |=> $stable(mode_q));
endmodule

// File: rtl/sbus_cmd_frontend.sv
module sbus_cmd_frontend
    import sbus_pkg::*;
#(
    parameter int HAW = 8,
    parameter int HDW = 32,
    parameter int DW  = 8,
    parameter int LAW = 8,
    parameter int UAW = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_wr_en,
    input  logic               host_rd_en,
    input  logic [HAW-1:0]     host_addr,
    input  logic [HDW-1:0]     host_wdata,
    output logic [HDW-1:0]     host_rdata,
    output logic               tgt_req,
    output logic               tgt_we,
    output logic [UAW+LAW-1:0] tgt_addr,
    output logic [DW-1:0]      tgt_wdata,
    input  logic [DW-1:0]      tgt_rdata,
    input  logic               tgt_ack
);
    localparam int TAW = UAW + LAW;

    logic           ready, busy, avail;
    logic [DW-1:0]  rd_byte;
    logic           accept, acc_read, rdat_pop;
    logic [TAW-1:0] acc_addr;
    logic [DW-1:0]  acc_data;

    sbus_regwin #(.HAW(HAW), .HDW(HDW), .DW(DW), .LAW(LAW), .UAW(UAW)) u_regwin (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr_en (host_wr_en),
        .host_rd_en (host_rd_en),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .ready      (ready),
        .busy       (busy),
        .avail      (avail),
        .rd_byte    (rd_byte),
        .accept     (accept),
        .acc_read   (acc_read),
        .acc_addr   (acc_addr),
        .acc_data   (acc_data),
        .rdat_pop   (rdat_pop)
    );

    sbus_engine #(.DW(DW), .AW(TAW)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .acc_read  (acc_read),
        .acc_addr  (acc_addr),
        .acc_data  (acc_data),
        .rdat_pop  (rdat_pop),
        .tgt_ack   (tgt_ack),
        .tgt_rdata (tgt_rdata),
        .tgt_req   (tgt_req),
        .tgt_we    (tgt_we),
        .tgt_addr  (tgt_addr),
        .tgt_wdata (tgt_wdata),
        .ready     (ready),
        .busy      (busy),
        .avail     (avail),
        .rd_byte   (rd_byte)
    );
endmodule

// File: tb/sim_sbus_cmd_frontend.sv
`timescale 1ns/100ps
module sim_sbus_cmd_frontend;
    localparam logic [7:0] A_CMD = 8'h08, A_RDAT = 8'h10, A_STAT = 8'h14, A_MODE = 8'h1C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr_en = 1'b0, host_rd_en = 1'b0;
    logic [7:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        tgt_req, tgt_we;
    logic [14:0] tgt_addr;
    logic [7:0]  tgt_wdata, tgt_rdata;
    logic        tgt_ack = 1'b0;

    int checks = 0, fails = 0;
    int lat = 0, cnt = 0, wr_cnt = 0, rd_cnt = 0;
    logic [14:0] last_a = '0;
    logic [7:0]  last_d = '0;
    bit done = 0;

    always #2.5 clk = ~clk;

    sbus_cmd_frontend u0 (
        .clk(clk), .rst_n(rst_n), .host_wr_en(host_wr_en), .host_rd_en(host_rd_en),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .tgt_req(tgt_req), .tgt_we(tgt_we), .tgt_addr(tgt_addr), .tgt_wdata(tgt_wdata),
        .tgt_rdata(tgt_rdata), .tgt_ack(tgt_ack)
    );

    function automatic logic [7:0] model_byte(input logic [14:0] a);
        return a[7:0] ^ {1'b0, a[14:8]} ^ 8'hA5;
    endfunction

    assign tgt_rdata = model_byte(tgt_addr);

    // Target model with programmable acknowledge latency
    always @(negedge clk) begin
        if (!rst_n) begin
            tgt_ack = 1'b0; cnt = 0;
        end else if (tgt_ack) begin
            tgt_ack = 1'b0; cnt = 0;
        end else if (tgt_req) begin
            if (cnt >= lat) begin
                tgt_ack = 1'b1;
                if (tgt_we) begin wr_cnt++; last_a = tgt_addr; last_d = tgt_wdata; end
                else rd_cnt++;
            end else cnt++;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic hwr(input logic [7:0] a, input logic [31:0] d);
        host_addr = a; host_wdata = d; host_wr_en = 1'b1;
        @(negedge clk);
        host_wr_en = 1'b0;
    endtask

    task automatic hrd(input logic [7:0] a, output logic [31:0] v);
        host_addr = a; host_rd_en = 1'b1;
        #1 v = host_rdata;
        @(negedge clk);
        host_rd_en = 1'b0;
    endtask

    task automatic wait_ready();
        logic [31:0] s;
        for (int i = 0; i < 500; i++) begin
            hrd(A_STAT, s);
            if (s[1]) break;
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        hrd(A_STAT, v); check("R1 status", v, 32'h2);
        hrd(A_CMD,  v); check("R1 cmd",    v, 32'h0);
        hrd(A_MODE, v); check("R1 mode",   v, 32'h0);
        hrd(A_RDAT, v); check("R1 rdata",  v, 32'h0);
    endtask

    task automatic t_mode();
        logic [31:0] v;
        hwr(A_MODE, 32'hFFFF_FFFF);
        hrd(A_MODE, v); check("R8 mode unused bits", v, 32'h7FF);
        hwr(A_MODE, 32'h0000_035A);
        hrd(A_MODE, v); check("R8 mode field", v, 32'h35A);
    endtask

    task automatic t_write();
        logic [31:0] v;
        int w0 = wr_cnt;
        lat = 3;
        hwr(A_CMD, 32'hFE12_55C3);
        hrd(A_STAT, v); check("R2 busy after accept", v, 32'h1);
        check("R2 req/we", {30'd0, tgt_req, tgt_we}, 32'h3);
        check("R2 wdata", {24'd0, tgt_wdata}, 32'hC3);
        hrd(A_CMD, v); check("R8 cmd readback", v, 32'h0012_00C3);
        wait_ready();
        check("R4 req low", {31'd0, tgt_req}, 32'h0);
        hrd(A_STAT, v); check("R4 status ready", v, 32'h2);
        check("R4 one write", wr_cnt - w0, 1);
        check("R3 write address", {17'd0, last_a}, 32'h3512);
        check("R4 write data", {24'd0, last_d}, 32'hC3);
    endtask

    task automatic t_read();
        logic [31:0] v;
        logic [7:0]  e = model_byte(15'h3540);
        lat = 5;
        hwr(A_CMD, 32'h0140_0000);
        check("R2 read we low", {30'd0, tgt_req, tgt_we}, 32'h2);
        check("R3 read address", {17'd0, tgt_addr}, 32'h3540);
        wait_ready();
        hrd(A_STAT, v); check("R5 status avail", v, 32'h6);
        hrd(A_RDAT, v); check("R5 read byte", v, {24'd0, e});
        hrd(A_STAT, v); check("R7 pop clears avail", v, 32'h2);
        hrd(A_RDAT, v); check("R10 byte persists", v, {24'd0, e});
    endtask

    task automatic t_ignore();
        logic [31:0] v;
        int w0 = wr_cnt;
        lat = 8;
        hwr(A_CMD, 32'h0021_0011);
        hwr(A_CMD, 32'h0077_0099);
        hrd(A_CMD, v); check("R6 cmd unchanged", v, 32'h0021_0011);
        hwr(A_MODE, 32'h0000_001A);
        check("R3 in-flight address held", {17'd0, tgt_addr}, 32'h3521);
        wait_ready();
        repeat (4) @(negedge clk);
        check("R6 no extra transaction", {31'd0, tgt_req}, 32'h0);
        check("R6 single write", wr_cnt - w0, 1);
        check("R6 write fields", {9'd0, last_a, last_d}, {9'd0, 15'h3521, 8'h11});
        hwr(A_MODE, 32'h0000_035A);
    endtask

    task automatic t_avail_cmd();
        logic [31:0] v;
        lat = 0;
        hwr(A_CMD, 32'h0100_0007);
        wait_ready();
        hrd(A_STAT, v); check("R5 avail at latency 0", v, 32'h6);
        lat = 4;
        hwr(A_CMD, 32'h0033_0044);
        hrd(A_STAT, v); check("R7 new command clears avail", v, 32'h1);
        wait_ready();
        check("R4 latency-4 write", {9'd0, last_a, last_d}, {9'd0, 15'h3533, 8'h44});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mode();
        t_write();
        t_read();
        t_ignore();
        t_avail_cmd();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule